// File: doc/BRIEF.md
# Synchronous Processor Bus Register Slave

This block sits between a synchronous processor bus and an internal byte-wide register space. It samples chip select, a direction line, separate read and write strobes, an 18-bit address and write data on the rising edge of the bus clock, and answers each transfer with a one-cycle active-low transfer acknowledge. The master cannot count cycles to find the end of an access, because the response time depends on the address. It must wait for the acknowledge.

Inside, a cycle sequencer latches the address and direction when chip select falls. It waits for the strobe that matches the direction, then issues one request on a valid/ready register port. A small register file answers after a latency set by parameter for each address region, so the variable response time can be exercised. Read data is driven through a split output/enable pair, which a pad ring can merge into a bidirectional bus.

Top module: `pbus_slave`

## Requirements
- R1: After reset `ta_n` is high and `doe` is low.
- R2: A read (`rd_wr`=1 at chip-select assertion, then `dben_n` low) returns on `dout` the byte held at the addressed register in the cycle where `ta_n` is low. `doe` is high in that cycle.
- R3: A write (`rd_wr`=0, then `we_n` low) stores the `din` byte sampled on the first edge where `we_n` is seen low. A later read of the same address returns it.
- R4: Address bits [3:2] select a latency region of 1, 2, 4 or 6 cycles (region 0 to 3). `ta_n` goes low on the (L+2)th rising edge after chip select and the strobe are first sampled low together.
- R5: `ta_n` is low for exactly one cycle per transfer. It stays high while chip select remains asserted after the acknowledge.
- R6: `doe` is high only while `cs_n` and `dben_n` are both low in a read cycle. It stays low throughout write cycles and before the read strobe arrives.
- R7: Releasing `cs_n` before the acknowledge aborts the cycle. No acknowledge follows and the write is not committed.
- R8: Addresses 16 and above read as 0x00 and ignore writes. They are still acknowledged, with a latency of 1 cycle.
- R9: While chip select is asserted without the matching strobe, the cycle stalls with `ta_n` high. Once the strobe is sampled low, the acknowledge follows after L+1 further edges.
- R10: The address is taken at chip-select assertion. Changes on `addr` later in the cycle do not alter the register accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | Direction: 1 read, 0 write |
| we_n | input | 1 | Write strobe, active low |
| dben_n | input | 1 | Read data-bus enable, active low |
| addr | input | 18 | Register address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| doe | output | 1 | Output enable for the data bus pads |
| ta_n | output | 1 | Transfer acknowledge, active low |

## Verification
A sequencer stuck in its request or hold state shows up as a missing acknowledge or an extra one. The bench counts edges from chip select, so it catches this within L+2 cycles of the transfer. A wrong latency region or a counter off by one moves the acknowledge by whole cycles, and the bench compares that cycle count against the region table. A corrupted latched address, direction or write byte stays hidden until a later read of that register returns the wrong byte, which is why every write in the bench is read back.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_STROBE = 3'd1,
    ST_REQ    = 3'd2,
    ST_ACK    = 3'd3,
    ST_HOLD   = 3'd4
  } cyc_state_t;
endpackage

// File: rtl/pbus_cycle_fsm.sv
module pbus_cycle_fsm
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              we_n,
  input  logic              dben_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din,
  output logic              ta_n,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              req_valid,
  output logic              req_wr,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic [DATA_W-1:0] rsp_rdata
);
  cyc_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              ld_cyc, ld_wd, ld_rd;
  logic              strobe_ok;

  assign strobe_ok = rd_q ? ~dben_n : ~we_n;

  always_comb begin
    st_d   = st_q;
    ld_cyc = 1'b0;
    ld_wd  = 1'b0;
    ld_rd  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (!cs_n) begin
          st_d   = ST_STROBE;
          ld_cyc = 1'b1;
        end
      end
      ST_STROBE: begin
        if (cs_n) begin
          st_d = ST_IDLE;
        end else if (strobe_ok) begin
          st_d  = ST_REQ;
          ld_wd = ~rd_q;
        end
      end
      ST_REQ: begin
        if (cs_n) begin
          st_d = ST_IDLE;
        end else if (req_ready) begin
          st_d  = ST_ACK;
          ld_rd = rd_q;
        end
      end
      ST_ACK: st_d = ST_HOLD;
      ST_HOLD: begin
        if (cs_n) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b1;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld_cyc) begin
        addr_q <= addr_in;
        rd_q   <= rd_wr;
      end
      if (ld_wd) wdata_q <= din;
      if (ld_rd) rdata_q <= rsp_rdata;
    end
  end

  assign req_valid = (st_q == ST_REQ) && !cs_n;
  assign req_wr    = ~rd_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign ta_n      = (st_q != ST_ACK);
  assign dout      = rdata_q;
  assign doe       = rd_q && !cs_n && !dben_n && (st_q != ST_IDLE);
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
  parameter int                    ADDR_W    = 18,
  parameter int                    DATA_W    = 8,
  parameter int                    NREG      = 16,
  parameter int                    LAT_W     = 3,
  parameter logic [3:0][LAT_W-1:0] LAT_TABLE = {3'd6, 3'd4, 3'd2, 3'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int IDX_W = $clog2(NREG);

  logic [DATA_W-1:0] regs [NREG];
  logic [IDX_W-1:0]  idx;
  logic [1:0]        region;
  logic              in_range;
  logic [LAT_W-1:0]  lat, cnt_q, cnt_d;
  logic              commit;

  assign idx      = req_addr[IDX_W-1:0];
  assign region   = req_addr[IDX_W-1 -: 2];
  assign in_range = (req_addr < ADDR_W'(NREG));
  assign lat      = in_range ? LAT_TABLE[region] : LAT_W'(1);

  assign req_ready = req_valid && (cnt_q == (lat - LAT_W'(1)));
  assign commit    = req_ready && req_wr && in_range;
  assign cnt_d     = (req_valid && !req_ready) ? cnt_q + LAT_W'(1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wen;
    assign wen = commit && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (wen) regs[g] <= req_wdata;
    end
  end

  assign rsp_rdata = in_range ? regs[idx] : '0;
endmodule

// File: rtl/pbus_slave.sv
module pbus_slave #(
  parameter int                    ADDR_W    = 18,
  parameter int                    DATA_W    = 8,
  parameter int                    NREG      = 16,
  parameter int                    LAT_W     = 3,
  parameter logic [3:0][LAT_W-1:0] LAT_TABLE = {3'd6, 3'd4, 3'd2, 3'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_wr,
  input  logic              we_n,
  input  logic              dben_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              doe,
  output logic              ta_n
);
  logic              req_valid, req_wr, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata, rsp_rdata;

  pbus_cycle_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .we_n(we_n),
    .dben_n(dben_n), .addr_in(addr), .din(din), .ta_n(ta_n), .dout(dout),
    .doe(doe), .req_valid(req_valid), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata)
  );

  pbus_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NREG(NREG),
    .LAT_W(LAT_W), .LAT_TABLE(LAT_TABLE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
  parameter int ADDR_W = 18,
  parameter int NREG   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              dben_n,
  input logic              ta_n,
  input logic              doe,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr
);
  p_ta_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ta_n |=> ta_n);

  p_ta_after_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ta_n) |-> $past(req_valid && req_ready));

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!cs_n && !dben_n));

  p_oob_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr >= ADDR_W'(NREG))) |-> req_ready);

  p_release_no_ta_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> ta_n);
endmodule

bind pbus_slave pbus_slave_chk #(.ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dben_n(dben_n), .ta_n(ta_n),
  .doe(doe), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr)
);

// File: tb/pbus_slave_tb.sv
module pbus_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, cs_n, rd_wr, we_n, dben_n;
  logic [17:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        doe, ta_n;
  int          checks = 0;
  int          fails = 0;
  logic [7:0]  model [16];

  always #2.5 clk = ~clk;

  pbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .we_n(we_n),
    .dben_n(dben_n), .addr(addr), .din(din), .dout(dout), .doe(doe),
    .ta_n(ta_n)
  );

  // {write, addr[17:0], data[7:0]}
  localparam int NV = 11;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 18'h00000, 8'h11}, {1'b1, 18'h00005, 8'h55},
    {1'b1, 18'h0000A, 8'hA3}, {1'b1, 18'h0000F, 8'hF0},
    {1'b1, 18'h20000, 8'h77}, {1'b0, 18'h00000, 8'h00},
    {1'b0, 18'h00005, 8'h00}, {1'b0, 18'h0000A, 8'h00},
    {1'b0, 18'h0000F, 8'h00}, {1'b0, 18'h20000, 8'h00},
    {1'b0, 18'h00003, 8'h00}
  };

  function automatic int exp_lat(input logic [17:0] a);
    if (a >= 18'd16) return 1;
    case (a[3:2])
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic release_bus();
    cs_n = 1'b1; we_n = 1'b1; dben_n = 1'b1; rd_wr = 1'b1;
  endtask

  task automatic xfer(input logic wr, input logic [17:0] a, input logic [7:0] d,
                      output logic [7:0] got, output int cyc, output logic oe_ta);
    @(negedge clk);
    rd_wr = ~wr; addr = a; cs_n = 1'b0;
    if (wr) begin we_n = 1'b0; din = d; end
    else dben_n = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (ta_n && cyc < 40);
    got = dout; oe_ta = doe;
    @(negedge clk);
    chk(ta_n == 1'b1, "R5 ta one cycle", ta_n, 1);
    release_bus();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    int         cyc;
    logic       oe_ta;
    rst_n = 1'b0; addr = '0; din = '0;
    release_bus();
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(ta_n == 1'b1, "R1 reset ta_n", ta_n, 1);
    chk(doe == 1'b0, "R1 reset doe", doe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ta_n == 1'b1 && doe == 1'b0, "R1 idle after reset", {ta_n, doe}, 2);

    // vector walk: R2 R3 R4 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [17:0] a;
      logic [7:0]  d, exp_d;
      w = VEC[v][26]; a = VEC[v][25:8]; d = VEC[v][7:0];
      exp_d = (a < 18'd16) ? model[a[3:0]] : 8'h00;
      xfer(w, a, d, got, cyc, oe_ta);
      chk(cyc == exp_lat(a) + 2, "R4 latency", cyc, exp_lat(a) + 2);
      if (w) begin
        if (a < 18'd16) model[a[3:0]] = d;
        chk(oe_ta == 1'b0, "R6 no drive in write", oe_ta, 0);
      end else begin
        chk(got == exp_d, (a >= 18'd16) ? "R8 out of range read" : "R2 R3 read data",
            got, exp_d);
        chk(oe_ta == 1'b1, "R2 drive at ta", oe_ta, 1);
      end
    end

    // R7: abort a write to register 13 during its access wait
    @(negedge clk);
    rd_wr = 1'b0; addr = 18'd13; cs_n = 1'b0; we_n = 1'b0; din = 8'h3C;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ta_n == 1'b1, "R7 no ta before abort", ta_n, 1);
    end
    release_bus();
    repeat (3) begin
      @(negedge clk);
      chk(ta_n == 1'b1, "R7 no ta after abort", ta_n, 1);
    end
    xfer(1'b0, 18'd13, 8'h00, got, cyc, oe_ta);
    chk(got == 8'h00, "R7 aborted write not committed", got, 0);
    chk(cyc == 8, "R4 region 3 latency", cyc, 8);

    // R9: stall without read strobe, then strobe
    @(negedge clk);
    rd_wr = 1'b1; addr = 18'd5; cs_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(ta_n == 1'b1, "R9 stall no ta", ta_n, 1);
      chk(doe == 1'b0, "R6 no drive before dben", doe, 0);
    end
    dben_n = 1'b0;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (ta_n && cyc < 40);
    chk(cyc == 3, "R9 ta after strobe", cyc, 3);
    chk(dout == 8'h55, "R9 R2 stalled read data", dout, 8'h55);
    // R5: keep chip select low, no second acknowledge
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(ta_n == 1'b1, "R5 no repeat ta", ta_n, 1);
    end
    release_bus();
    @(negedge clk);
    chk(doe == 1'b0, "R6 released bus", doe, 0);

    // R10: address changes after chip select
    @(negedge clk);
    rd_wr = 1'b1; addr = 18'd10; cs_n = 1'b0; dben_n = 1'b0;
    @(negedge clk);
    addr = 18'd5;
    cyc = 1;
    do begin @(negedge clk); cyc++; end while (ta_n && cyc < 40);
    chk(dout == 8'hA3, "R10 latched address", dout, 8'hA3);
    chk(cyc == 6, "R10 R4 latched region latency", cyc, 6);
    release_bus();
    @(negedge clk);

    // R8: out-of-range write left register 0 untouched
    xfer(1'b0, 18'h20000, 8'h00, got, cyc, oe_ta);
    chk(got == 8'h00, "R8 out of range still zero", got, 0);
    xfer(1'b0, 18'h00000, 8'h00, got, cyc, oe_ta);
    chk(got == 8'h11, "R8 alias not written", got, 8'h11);

    finish_run();
  end
endmodule